// File: doc/BRIEF.md
# Two-Wire EEPROM Slave with Row Buffer

This block is the slave side of a two-wire serial bus placed in front of a small nonvolatile word store of 32 rows by 16 bits, kept here as registers. The bus lines are oversampled by the block's own clock. START and STOP conditions are recovered from the sampled SCL and SDA. The slave answers on SDA only by pulling it low, and releases it at every other time.

Every transaction opens with a control byte that names a row, a byte order and a direction. That row is copied into a 16-bit buffer, and all later data moves through this buffer. Reads may continue past the end of the row. The row index then steps up or down and wraps at either end of the array. Writes hand one or two bytes to the buffer and start a timed erase phase. A program phase follows at STOP and stores the buffer back to the row. While either phase runs, the slave acknowledges no control byte, so a master can poll for completion.

Control bytes that name special modes are acknowledged and passed out with a one-cycle strobe for neighbouring logic to decode. Reserved control bytes are refused.

Top module: `tw_eeprom_slave`

## Requirements
- R1: The slave never pulls SDA low in standby. An SDA fall while SCL is high (START) starts reception of a new control byte from any state. An SDA rise while SCL is high (STOP) returns the slave to standby.
- R2: The control byte is received MSB first. Bits [7:3] are the row, bits [2:1] are the mode and bit 0 is the direction (0 write, 1 read). A byte with mode 01 or 10 is acknowledged by pulling SDA low during the ninth SCL pulse.
- R3: A write with mode 01 puts its first data byte in the low half of the row and its second in the high half. Mode 10 does the reverse. A half that is not written keeps the row's previous content.
- R4: A read with mode 01 returns the low half and then the high half. Mode 10 returns the high half and then the low half. Each byte is sent MSB first.
- R5: After two bytes of a read have been acknowledged by the master, the row becomes row+1 for mode 01 or row-1 for mode 10, modulo 32, and the buffer reloads from that row.
- R6: After a master not-acknowledge on a read byte, the slave releases SDA and drives nothing more until the next START.
- R7: Acknowledging the first write data byte starts an erase phase of ERASE_CYC clocks. A second data byte is acknowledged and stored only if it ends within that phase. Otherwise it is not acknowledged and is discarded. Further data bytes are never acknowledged.
- R8: A program phase of PROG_CYC clocks starts at STOP or at the end of erase, whichever comes later. When it ends, the buffer is written to the row.
- R9: While an erase or program phase is pending or running, no control byte is acknowledged.
- R10: A write that sends only its control byte starts no erase or program phase. An immediately following control byte is acknowledged.
- R11: A control byte with bits [2:0]=111 and bits [7:6]=11 is acknowledged. It pulses spec_stb_o for one clock with the byte on spec_byte_o and leaves the array untouched. The slave then stays passive until STOP.
- R12: Any other control byte, including those ending in 110 and those with mode 00 or 11, is not acknowledged and does not touch the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock, oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| spec_stb_o | output | 1 | One-clock strobe on an accepted special control byte |
| spec_byte_o | output | 8 | Last accepted special control byte |

## Verification
Each bus input passes SYNC_STAGES flops and one edge register. A slave decision that follows an SCL fall therefore appears on SDA about four clocks after that fall. The bench drives SDA one quarter phase of six clocks after each SCL fall and samples in the middle of the SCL high phase, so the answer is always settled when it is read. The erase window is counted from the acknowledge that accepts the first data byte. The late-byte case waits a full erase length plus margin, and the first poll after STOP falls well inside the busy window. The special strobe is counted by a monitor on spec_stb_o. The count is checked a few clocks after the acknowledge.

// File: rtl/tw_eeprom_pkg.sv
package tw_eeprom_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ROW_W  = 5;
  localparam int unsigned ROWS   = 1 << ROW_W;
  localparam int unsigned WORD_W = 2 * BYTE_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK, ST_PASS
  } bus_st_e;

  typedef enum logic [1:0] {
    NV_IDLE, NV_ERASE, NV_HOLD, NV_PROG
  } nv_st_e;
endpackage

// File: rtl/tw_bus_cond.sv
module tw_bus_cond #(
  parameter int unsigned SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC-1:0] scl_q, sda_q;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[SYNC-2:0], scl_i};
      sda_q <= {sda_q[SYNC-2:0], sda_i};
      scl_d <= scl_q[SYNC-1];
      sda_d <= sda_q[SYNC-1];
    end
  end

  assign scl_s      = scl_q[SYNC-1];
  assign sda_o      = sda_q[SYNC-1];
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  assign start_o    = scl_s & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/tw_nv_timer.sv
module tw_nv_timer import tw_eeprom_pkg::*; #(
  parameter int unsigned ERASE_CYC = 2500000,
  parameter int unsigned PROG_CYC  = 2500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic erase_go_i,
  input  logic stop_i,
  output logic busy_o,
  output logic erase_o,
  output logic wr_en_o
);
  localparam int unsigned MAXC  = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int unsigned CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] ERASE_LD = CNT_W'(ERASE_CYC - 1);
  localparam logic [CNT_W-1:0] PROG_LD  = CNT_W'(PROG_CYC - 1);

  nv_st_e st;
  logic [CNT_W-1:0] cnt;
  logic stop_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st        <= NV_IDLE;
      cnt       <= '0;
      stop_seen <= 1'b0;
    end else begin
      unique case (st)
        NV_IDLE: if (erase_go_i) begin
          st        <= NV_ERASE;
          cnt       <= ERASE_LD;
          stop_seen <= 1'b0;
        end
        NV_ERASE: begin
          if (stop_i) stop_seen <= 1'b1;
          if (cnt == '0) begin
            if (stop_seen || stop_i) begin
              st  <= NV_PROG;
              cnt <= PROG_LD;
            end else begin
              st <= NV_HOLD;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        NV_HOLD: if (stop_i) begin
          st  <= NV_PROG;
          cnt <= PROG_LD;
        end
        NV_PROG: begin
          if (cnt == '0) st <= NV_IDLE;
          else           cnt <= cnt - 1'b1;
        end
        default: st <= NV_IDLE;
      endcase
    end
  end

  assign busy_o  = (st != NV_IDLE);
  assign erase_o = (st == NV_ERASE);
  assign wr_en_o = (st == NV_PROG) && (cnt == '0);

  p_prog_entry_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st == NV_PROG) |-> ($past(st) == NV_ERASE || $past(st) == NV_HOLD));
  p_hold_waits_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == NV_HOLD && !stop_i) |=> (st == NV_HOLD));
endmodule

// File: rtl/tw_row_array.sv
module tw_row_array import tw_eeprom_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ROW_W-1:0]  rd_row_i,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [ROW_W-1:0]  wr_row_i,
  input  logic [WORD_W-1:0] wr_data_i
);
  logic [ROWS-1:0][WORD_W-1:0] mem;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mem <= '0;
    else if (wr_en_i) mem[wr_row_i] <= wr_data_i;
  end

  assign rd_data_o = mem[rd_row_i];

  p_row_update_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (mem[$past(wr_row_i)] == $past(wr_data_i)));
endmodule

// File: rtl/tw_eeprom_slave.sv
module tw_eeprom_slave import tw_eeprom_pkg::*; #(
  parameter int unsigned ERASE_CYC   = 2500000,
  parameter int unsigned PROG_CYC    = 2500000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  output logic              spec_stb_o,
  output logic [BYTE_W-1:0] spec_byte_o
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic nv_busy, nv_erase, nv_wr;

  bus_st_e st;
  logic [3:0]        bit_cnt;
  logic [BYTE_W-1:0] sh;
  logic              is_ctrl, rw_q, lo_first_q, pos_q, ack_q, m_ack_q, spec_q;
  logic [1:0]        wr_n_q;
  logic [ROW_W-1:0]  row_q;
  logic [WORD_W-1:0] buf_q, row_data;

  function automatic logic [BYTE_W-1:0] pick(logic [WORD_W-1:0] w, logic low);
    return low ? w[BYTE_W-1:0] : w[WORD_W-1:BYTE_W];
  endfunction

  tw_bus_cond #(.SYNC(SYNC_STAGES)) u_cond (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  // control byte decode
  logic [ROW_W-1:0] ctrl_row, nxt_row, rd_row;
  logic [1:0] ctrl_mode;
  logic ctrl_spec, ctrl_valid, acc_ctrl, acc_d0, acc_d1, rx_done, erase_go, wr_low;

  assign ctrl_row   = sh[7:3];
  assign ctrl_mode  = sh[2:1];
  assign ctrl_spec  = (sh[2:0] == 3'b111) && (sh[7:6] == 2'b11);
  assign ctrl_valid = (ctrl_mode == 2'b01) || (ctrl_mode == 2'b10);
  assign acc_ctrl   = !nv_busy && (ctrl_valid || ctrl_spec);
  assign acc_d0     = (wr_n_q == 2'd0) && !nv_busy;
  assign acc_d1     = (wr_n_q == 2'd1) && nv_erase;
  assign rx_done    = (st == ST_RX) && scl_fall && (bit_cnt == 4'd8);
  assign erase_go   = rx_done && !is_ctrl && acc_d0;
  assign wr_low     = lo_first_q ^ wr_n_q[0];
  assign nxt_row    = lo_first_q ? row_q + 1'b1 : row_q - 1'b1;
  assign rd_row     = (st == ST_RX) ? ctrl_row : nxt_row;

  tw_row_array u_array (
    .clk_i, .rst_ni, .rd_row_i(rd_row), .rd_data_o(row_data),
    .wr_en_i(nv_wr), .wr_row_i(row_q), .wr_data_i(buf_q)
  );

  tw_nv_timer #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) u_timer (
    .clk_i, .rst_ni, .erase_go_i(erase_go), .stop_i(stop_det),
    .busy_o(nv_busy), .erase_o(nv_erase), .wr_en_o(nv_wr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= ST_IDLE;  bit_cnt <= '0;  sh <= '0;
      is_ctrl <= 1'b0; rw_q <= 1'b0; lo_first_q <= 1'b0; pos_q <= 1'b0;
      ack_q <= 1'b0;  m_ack_q <= 1'b0; spec_q <= 1'b0; wr_n_q <= '0;
      row_q <= '0;    buf_q <= '0;   spec_stb_o <= 1'b0; spec_byte_o <= '0;
    end else begin
      spec_stb_o <= 1'b0;
      if (start_det) begin
        st <= ST_RX; is_ctrl <= 1'b1; bit_cnt <= '0;
      end else if (stop_det) begin
        st <= ST_IDLE;
      end else begin
        unique case (st)
          ST_RX: begin
            if (scl_rise) begin
              sh      <= {sh[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (rx_done) begin
              bit_cnt <= '0;
              st      <= ST_ACK;
              if (is_ctrl) begin
                ack_q  <= acc_ctrl;
                spec_q <= acc_ctrl && ctrl_spec;
                if (acc_ctrl && ctrl_spec) begin
                  spec_stb_o  <= 1'b1;
                  spec_byte_o <= sh;
                end
                if (acc_ctrl && ctrl_valid) begin
                  rw_q       <= sh[0];
                  lo_first_q <= (ctrl_mode == 2'b01);
                  row_q      <= ctrl_row;
                  buf_q      <= row_data;
                  pos_q      <= 1'b0;
                  wr_n_q     <= '0;
                end
              end else begin
                ack_q <= acc_d0 || acc_d1;
                if (acc_d0 || acc_d1) begin
                  wr_n_q <= wr_n_q + 1'b1;
                  if (wr_low) buf_q[BYTE_W-1:0]      <= sh;
                  else        buf_q[WORD_W-1:BYTE_W] <= sh;
                end
              end
            end
          end
          ST_ACK: if (scl_fall) begin
            is_ctrl <= 1'b0;
            if (!ack_q || (is_ctrl && spec_q)) st <= ST_PASS;
            else if (is_ctrl && rw_q) begin
              st <= ST_TX;
              sh <= pick(buf_q, lo_first_q);
            end else st <= ST_RX;
          end
          ST_TX: begin
            if (scl_rise) bit_cnt <= bit_cnt + 1'b1;
            else if (scl_fall) begin
              if (bit_cnt == 4'd8) begin
                st      <= ST_MACK;
                bit_cnt <= '0;
              end else sh <= {sh[BYTE_W-2:0], 1'b0};
            end
          end
          ST_MACK: begin
            if (scl_rise) m_ack_q <= ~sda_s;
            else if (scl_fall) begin
              if (m_ack_q) begin
                st <= ST_TX;
                if (pos_q) begin
                  row_q <= nxt_row;
                  buf_q <= row_data;
                  pos_q <= 1'b0;
                  sh    <= pick(row_data, lo_first_q);
                end else begin
                  pos_q <= 1'b1;
                  sh    <= pick(buf_q, !lo_first_q);
                end
              end else st <= ST_PASS;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o = (st == ST_ACK && ack_q) || (st == ST_TX && !sh[BYTE_W-1]);

  p_start_release_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> (st == ST_RX && !sda_pull_o));
  p_nack_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_MACK && scl_fall && !m_ack_q && !start_det && !stop_det) |=> !sda_pull_o);
  p_busy_nack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done && is_ctrl && nv_busy && !start_det && !stop_det) |=> !sda_pull_o);
  p_reserved_nack_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done && is_ctrl && sh[2:0] == 3'b110 && !start_det && !stop_det) |=> !sda_pull_o);
  p_spec_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spec_stb_o |=> !spec_stb_o);
endmodule

// File: tb/tb_tw_eeprom_slave.sv
module tb_tw_eeprom_slave;
  localparam int Q     = 6;
  localparam int ERASE = 2000;
  localparam int PROG  = 2000;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_low = 1'b0;
  logic sda_pull, spec_stb, sda_bus;
  logic [7:0] spec_byte;
  assign sda_bus = !(m_low || sda_pull);
  always #2 clk = ~clk;

  tw_eeprom_slave #(.ERASE_CYC(ERASE), .PROG_CYC(PROG)) dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .spec_stb_o(spec_stb), .spec_byte_o(spec_byte)
  );

  int n_vec = 0, n_err = 0, spec_cnt = 0;
  logic [7:0] spec_last = '0;
  bit done = 0;
  logic [15:0] model [32];

  always @(posedge clk) if (spec_stb) begin
    spec_cnt  <= spec_cnt + 1;
    spec_last <= spec_byte;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic qwait; repeat (Q) @(negedge clk); endtask

  task automatic bus_start;
    qwait; m_low = 0; qwait; scl = 1; qwait; m_low = 1; qwait; scl = 0;
  endtask

  task automatic bus_stop;
    qwait; m_low = 1; qwait; scl = 1; qwait; m_low = 0; qwait;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      qwait; m_low = !b[i]; qwait; scl = 1; qwait; qwait; scl = 0;
    end
    qwait; m_low = 0; qwait; scl = 1; qwait; ack = !sda_bus; qwait; scl = 0;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      qwait; m_low = 0; qwait; scl = 1; qwait; b[i] = sda_bus; qwait; scl = 0;
    end
    qwait; m_low = mack; qwait; scl = 1; qwait; qwait; scl = 0;
  endtask

  task automatic poll(input logic [7:0] c, output bit ack);
    bus_start; send_byte(c, ack); bus_stop;
  endtask

  function automatic logic [7:0] ctrl(input logic [4:0] row, input bit lo, input bit rd);
    return {row, (lo ? 2'b01 : 2'b10), rd};
  endfunction

  function automatic logic [7:0] exp_rd(input logic [4:0] row, input bit lo, input int i);
    logic [4:0] r;
    r = lo ? row + 5'(i / 2) : row - 5'(i / 2);
    return (lo ^ i[0]) ? model[r][7:0] : model[r][15:8];
  endfunction

  task automatic put(input logic [4:0] row, input bit low, input logic [7:0] b);
    if (low) model[row][7:0] = b; else model[row][15:8] = b;
  endtask

  task automatic do_write(input logic [4:0] row, input bit lo, input int n,
                          input logic [7:0] b0, input logic [7:0] b1, input bit late);
    bit ack;
    int polls;
    bus_start;
    send_byte(ctrl(row, lo, 0), ack);
    chk(ack, "R2 write control ack", ack, 1);
    if (n >= 1) begin
      send_byte(b0, ack);
      chk(ack, "R7 first data byte ack", ack, 1);
      put(row, lo, b0);
    end
    if (n == 2) begin
      if (late) repeat (ERASE + 500) @(negedge clk);
      send_byte(b1, ack);
      chk(ack == !late, late ? "R7 late byte refused" : "R7 in-erase byte ack", ack, !late);
      if (!late) put(row, !lo, b1);
    end
    bus_stop;
    if (n == 0) begin
      poll(ctrl(row, lo, 0), ack);
      chk(ack, "R10 no programming after control-only write", ack, 1);
    end else begin
      poll(ctrl(row, lo, 0), ack);
      chk(!ack, "R9 busy refuses control byte", ack, 0);
      polls = 1;
      while (!ack && polls < 60) begin
        poll(ctrl(row, lo, 0), ack);
        polls++;
      end
      chk(ack, "R8 program phase completes", polls, 60);
    end
  endtask

  task automatic do_read(input logic [4:0] row, input bit lo, input int n);
    bit ack;
    logic [7:0] b;
    bus_start;
    send_byte(ctrl(row, lo, 1), ack);
    chk(ack, "R2 read control ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      chk(b == exp_rd(row, lo, i), (i < 2) ? "R4 read byte order" : "R5 sequential row step",
          b, exp_rd(row, lo, i));
    end
    qwait;
    chk(!sda_pull, "R6 released after master nack", sda_pull, 0);
    bus_stop;
  endtask

  initial begin
    bit ack;
    int s;
    logic [7:0] b;
    void'($urandom(32'd7321));
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (5) @(negedge clk);
    chk(!sda_pull, "R1 released in reset", sda_pull, 0);
    chk(!spec_stb, "R11 no strobe in reset", spec_stb, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(!sda_pull, "R1 released in standby", sda_pull, 0);

    // directed corner cases
    do_write(5'd3, 1, 2, 8'hA5, 8'h3C, 0);
    do_read(5'd3, 1, 2);                       // R3 low-first placement
    do_write(5'd3, 0, 1, 8'h77, 8'h00, 0);     // R3 high half only
    do_read(5'd3, 0, 2);
    do_write(5'd31, 1, 2, 8'h12, 8'h34, 0);
    do_write(5'd0, 0, 2, 8'h56, 8'h78, 0);
    do_read(5'd31, 1, 4);                      // R5 wrap upward
    do_read(5'd0, 0, 4);                       // R5 wrap downward
    do_write(5'd10, 1, 2, 8'h11, 8'h22, 1);    // R7 late second byte
    do_read(5'd10, 1, 2);
    do_write(5'd12, 1, 0, 8'h00, 8'h00, 0);    // R10

    // R1 repeated start after a control-only write
    bus_start;
    send_byte(ctrl(5'd3, 1, 0), ack);
    chk(ack, "R1 control before restart", ack, 1);
    bus_start;
    send_byte(ctrl(5'd3, 1, 1), ack);
    chk(ack, "R1 control after restart", ack, 1);
    recv_byte(0, b);
    chk(b == model[3][7:0], "R1 data after restart", b, model[3][7:0]);
    bus_stop;

    // R11 special control byte
    s = spec_cnt;
    bus_start;
    send_byte(8'hC7, ack);
    chk(ack, "R11 special byte ack", ack, 1);
    repeat (4) @(negedge clk);
    chk(spec_cnt == s + 1, "R11 one strobe", spec_cnt, s + 1);
    chk(spec_last == 8'hC7, "R11 strobe byte", spec_last, 8'hC7);
    send_byte(8'h00, ack);
    chk(!ack, "R11 passive until stop", ack, 0);
    bus_stop;
    poll(ctrl(5'd24, 1, 0), ack);
    chk(ack, "R11 no programming started", ack, 1);
    do_read(5'd24, 1, 2);

    // R12 refused control bytes
    s = spec_cnt;
    poll(8'h56, ack); chk(!ack, "R12 reserved 110 refused", ack, 0);
    poll(8'hBF, ack); chk(!ack, "R12 111 without 11 top refused", ack, 0);
    poll(8'h40, ack); chk(!ack, "R12 mode 00 refused", ack, 0);
    poll(8'h47, ack); chk(!ack, "R12 mode 11 refused", ack, 0);
    chk(spec_cnt == s, "R12 no strobe", spec_cnt, s);

    // random mix
    for (int k = 0; k < 8; k++) begin
      do_write(5'($urandom % 32), bit'($urandom % 2), 1 + int'($urandom % 2),
               8'($urandom), 8'($urandom), 0);
    end
    for (int k = 0; k < 10; k++) begin
      do_read(5'($urandom % 32), bit'($urandom % 2), 1 + int'($urandom % 6));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end
endmodule